// File: doc/BRIEF.md
# Linked-List Descriptor Walker

This block drives one DMA channel through a chain of block descriptors kept in memory. A pulse on `start` passes in the byte address of the first descriptor. The walker then reads the seven-word descriptor through a word-wide memory port that allows one request at a time. It gives the source address, destination address, control word and item count to a block-transfer engine, and waits for that engine to report completion. When the block is done, it writes the engine's status word and the updated high control word, now carrying the done flag, back into the descriptor. It then follows the next pointer to the following descriptor.

Descriptor layout, in word order from the descriptor base address:

| Word | Contents |
|------|----------|
| 0 | source address |
| 1 | destination address |
| 2 | next pointer (master-select code in its low bits) |
| 3 | control low |
| 4 | control high (item count in bits 11:0, done flag in bit 12) |
| 5 | destination status low |
| 6 | destination status high |

Chaining happens only when bit 27 or bit 28 of the control low word is set. The chain ends at the first descriptor whose chaining bits are both clear, or whose next pointer is zero once its master-select bits are cleared. A memory error response stops the walk immediately.

Top module: `llp_chain_walker`

## Requirements
- R1: On a `start` pulse while idle, the walker reads words 0 to 6 of the descriptor in ascending order. Word k is read at address (`start_ptr` with bits 1:0 cleared) + 4·k. A `start` pulse while `busy` is high has no effect on the addresses read or on the results.
- R2: After the seventh word arrives and the count in word 4 bits 11:0 is between 1 and `MAX_COUNT` (2048), `blk_start` pulses for one cycle. While it is high, `blk_src` = word 0, `blk_dst` = word 1, `blk_ctl` = word 3 and `blk_count` = word 4 bits 11:0.
- R3: After `blk_done`, the walker writes `blk_stat` to word 5 and then writes word 4 with bit 12 set and every other bit unchanged. When the second write is acknowledged without error, `blk_cmplt` pulses for one cycle.
- R4: A count of zero starts no transfer. The walker writes 0 to word 5, writes word 4 with bit 12 set, and pulses `blk_cmplt`.
- R5: A count above `MAX_COUNT` (for example 2049 or 4095) raises `err` for one cycle. No transfer starts, nothing is written back, and the walker returns to idle. A count of exactly 2048 is accepted.
- R6: If bit 27 or bit 28 of word 3 is set, and word 2 with its low `LMS_W` (2) bits cleared is nonzero, the next descriptor is read from that cleared address after `blk_cmplt`.
- R7: When both chaining bits are clear, or the cleared next pointer is zero, `chain_cmplt` pulses in the same cycle as the final `blk_cmplt`. `busy` is low in that cycle.
- R8: A memory response with `mem_err` high, on a read or on a write-back, raises `err` for one cycle with `busy` already low. No further memory request is issued, and no `blk_cmplt` or `chain_cmplt` follows.
- R9: `mem_req` is high for one cycle per access. No new request is issued before `mem_ack` answers the previous one, and every request address has bits 1:0 equal to zero.
- R10: After reset, `busy`, `mem_req`, `blk_start`, `blk_cmplt`, `chain_cmplt` and `err` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin walking a chain |
| start_ptr | input | AW | Byte address of the first descriptor |
| busy | output | 1 | Chain walk in progress |
| mem_req | output | 1 | One-cycle memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Response for the outstanding access |
| mem_err | input | 1 | Response carries an error (valid with `mem_ack`) |
| mem_rdata | input | DW | Read data (valid with `mem_ack`) |
| blk_start | output | 1 | One-cycle pulse that launches a block transfer |
| blk_src | output | DW | Source address of the block |
| blk_dst | output | DW | Destination address of the block |
| blk_ctl | output | DW | Control low word of the block |
| blk_count | output | CNT_W | Items in the block |
| blk_done | input | 1 | Engine finished the block |
| blk_stat | input | DW | Engine status, sampled with `blk_done` |
| blk_cmplt | output | 1 | One-cycle pulse: block written back |
| chain_cmplt | output | 1 | One-cycle pulse: last block of the chain done |
| err | output | 1 | One-cycle pulse: walk aborted |

## Verification
The bench builds the walker with a 16-bit address (`AW`=16) and keeps every other parameter at its default. With these values all descriptors fit in a 128-word memory model, while the count limit stays at its full 2048 value, so the counts 0, 1, 2047, 2048, 2049 and 4095 can all be applied. The sweep covers:
- chains of one to four descriptors, with every master-select code and every chaining-bit combination;
- memory latencies of one to three cycles;
- an error injected on every word read and on both write-backs of each descriptor of a two-deep chain.

Because the address space is this small, each address the walker reads or writes is compared in order against a list the bench computes from the descriptors.

// File: rtl/llw_pkg.sv
package llw_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_ISSUE,
    S_RD_WAIT,
    S_DECIDE,
    S_XFER_WAIT,
    S_WBS_ISSUE,
    S_WBS_WAIT,
    S_WBC_ISSUE,
    S_WBC_WAIT
  } walk_state_t;

  // Word positions inside a descriptor
  localparam int unsigned WI_SRC    = 0;
  localparam int unsigned WI_DST    = 1;
  localparam int unsigned WI_NEXT   = 2;
  localparam int unsigned WI_CTLLO  = 3;
  localparam int unsigned WI_CTLHI  = 4;
  localparam int unsigned WI_STLO   = 5;
  localparam int unsigned WI_STHI   = 6;
  localparam int unsigned DESC_WORDS = 7;

endpackage

// File: rtl/llw_desc_store.sv
module llw_desc_store #(
  parameter int unsigned DW     = 32,
  parameter int unsigned NWORDS = 7,
  localparam int unsigned IDX_W = $clog2(NWORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    src_word,
  output logic [DW-1:0]    dst_word,
  output logic [DW-1:0]    next_word,
  output logic [DW-1:0]    ctl_lo_word,
  output logic [DW-1:0]    ctl_hi_word
);
  import llw_pkg::*;

  logic [DW-1:0] words_q [NWORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(NWORDS); i++) words_q[i] <= '0;
    end else if (wr_en) begin
      words_q[wr_idx] <= wr_data;
    end
  end

  assign src_word    = words_q[WI_SRC];
  assign dst_word    = words_q[WI_DST];
  assign next_word   = words_q[WI_NEXT];
  assign ctl_lo_word = words_q[WI_CTLLO];
  assign ctl_hi_word = words_q[WI_CTLHI];

endmodule

// File: rtl/llw_addr_gen.sv
module llw_addr_gen #(
  parameter int unsigned AW    = 32,
  parameter int unsigned LMS_W = 2,
  parameter int unsigned IDX_W = 3,
  localparam int unsigned CLR_W = (LMS_W > 2) ? LMS_W : 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [AW-1:0]    load_ptr,
  input  logic [IDX_W-1:0] idx,
  input  logic [AW-1:0]    next_ptr,
  output logic [AW-1:0]    word_addr,
  output logic             next_null
);
  localparam logic [AW-1:0] KEEP_MASK = ~AW'((1 << CLR_W) - 1);

  logic [AW-1:0] base_q;

  always_ff @(posedge clk) begin
    if (rst)       base_q <= '0;
    else if (load) base_q <= load_ptr & KEEP_MASK;
  end

  assign word_addr = base_q + (AW'(idx) << 2);
  assign next_null = ((next_ptr & KEEP_MASK) == '0);

endmodule

// File: rtl/llw_seq.sv
module llw_seq #(
  parameter int unsigned AW            = 32,
  parameter int unsigned DW            = 32,
  parameter int unsigned CNT_W         = 12,
  parameter int unsigned MAX_COUNT     = 2048,
  parameter int unsigned DONE_BIT      = 12,
  parameter int unsigned SRC_CHAIN_BIT = 28,
  parameter int unsigned DST_CHAIN_BIT = 27,
  parameter int unsigned IDX_W         = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    start_ptr,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic             blk_done,
  input  logic [DW-1:0]    blk_stat,
  input  logic [DW-1:0]    ctl_lo,
  input  logic [DW-1:0]    ctl_hi,
  input  logic [AW-1:0]    next_ptr,
  input  logic             next_null,
  input  logic [AW-1:0]    word_addr,
  output logic             base_load,
  output logic [AW-1:0]    base_ptr,
  output logic [IDX_W-1:0] widx,
  output logic             fetch_wr,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic             blk_start,
  output logic             blk_cmplt,
  output logic             chain_cmplt,
  output logic             err,
  output logic             busy
);
  import llw_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);
  localparam logic [IDX_W-1:0] IDX_STLO = IDX_W'(WI_STLO);
  localparam logic [IDX_W-1:0] IDX_CTHI = IDX_W'(WI_CTLHI);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_COUNT);
  localparam logic [DW-1:0]    DONE_MASK = DW'(1) << DONE_BIT;

  walk_state_t    state_q;
  logic [DW-1:0]  stat_q;
  logic [CNT_W-1:0] cnt;
  logic           chain_on;
  logic           follow;

  assign cnt      = ctl_hi[CNT_W-1:0];
  assign chain_on = ctl_lo[SRC_CHAIN_BIT] | ctl_lo[DST_CHAIN_BIT];
  assign follow   = chain_on & ~next_null;

  assign base_load = ((state_q == S_IDLE) && start) ||
                     ((state_q == S_WBC_WAIT) && mem_ack && !mem_err && follow);
  assign base_ptr  = (state_q == S_IDLE) ? start_ptr : next_ptr;
  assign fetch_wr  = (state_q == S_RD_WAIT) && mem_ack && !mem_err;
  assign busy      = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      widx        <= '0;
      stat_q      <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      blk_start   <= 1'b0;
      blk_cmplt   <= 1'b0;
      chain_cmplt <= 1'b0;
      err         <= 1'b0;
    end else begin
      mem_req     <= 1'b0;
      blk_start   <= 1'b0;
      blk_cmplt   <= 1'b0;
      chain_cmplt <= 1'b0;
      err         <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            widx    <= '0;
            state_q <= S_RD_ISSUE;
          end
        end
        S_RD_ISSUE: begin
          mem_req  <= 1'b1;
          mem_we   <= 1'b0;
          mem_addr <= word_addr;
          state_q  <= S_RD_WAIT;
        end
        S_RD_WAIT: begin
          if (mem_ack) begin
            if (mem_err) begin
              err     <= 1'b1;
              state_q <= S_IDLE;
            end else if (widx == LAST_IDX) begin
              state_q <= S_DECIDE;
            end else begin
              widx    <= widx + 1'b1;
              state_q <= S_RD_ISSUE;
            end
          end
        end
        S_DECIDE: begin
          if (cnt > CNT_MAX) begin
            err     <= 1'b1;
            state_q <= S_IDLE;
          end else if (cnt == '0) begin
            stat_q  <= '0;
            widx    <= IDX_STLO;
            state_q <= S_WBS_ISSUE;
          end else begin
            blk_start <= 1'b1;
            state_q   <= S_XFER_WAIT;
          end
        end
        S_XFER_WAIT: begin
          if (blk_done) begin
            stat_q  <= blk_stat;
            widx    <= IDX_STLO;
            state_q <= S_WBS_ISSUE;
          end
        end
        S_WBS_ISSUE: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= word_addr;
          mem_wdata <= stat_q;
          state_q   <= S_WBS_WAIT;
        end
        S_WBS_WAIT: begin
          if (mem_ack) begin
            if (mem_err) begin
              err     <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              widx    <= IDX_CTHI;
              state_q <= S_WBC_ISSUE;
            end
          end
        end
        S_WBC_ISSUE: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= word_addr;
          mem_wdata <= ctl_hi | DONE_MASK;
          state_q   <= S_WBC_WAIT;
        end
        S_WBC_WAIT: begin
          if (mem_ack) begin
            if (mem_err) begin
              err     <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              blk_cmplt <= 1'b1;
              if (follow) begin
                widx    <= '0;
                state_q <= S_RD_ISSUE;
              end else begin
                chain_cmplt <= 1'b1;
                state_q     <= S_IDLE;
              end
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R9
  addr_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R9
  single_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    blk_start |-> (cnt != '0 && cnt <= CNT_MAX));

  // R3
  cmplt_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    blk_cmplt |-> $past(mem_ack && !mem_err));

  // R7
  chain_end_chk: assert property (@(posedge clk) disable iff (rst)
    chain_cmplt |-> (blk_cmplt && !busy));

  // R8
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (!busy && !blk_cmplt));

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> !mem_req);

endmodule

// File: rtl/llp_chain_walker.sv
module llp_chain_walker #(
  parameter int unsigned AW            = 32,
  parameter int unsigned DW            = 32,
  parameter int unsigned CNT_W         = 12,
  parameter int unsigned MAX_COUNT     = 2048,
  parameter int unsigned DONE_BIT      = 12,
  parameter int unsigned LMS_W         = 2,
  parameter int unsigned SRC_CHAIN_BIT = 28,
  parameter int unsigned DST_CHAIN_BIT = 27
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [AW-1:0]    start_ptr,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [DW-1:0]    mem_rdata,
  output logic             blk_start,
  output logic [DW-1:0]    blk_src,
  output logic [DW-1:0]    blk_dst,
  output logic [DW-1:0]    blk_ctl,
  output logic [CNT_W-1:0] blk_count,
  input  logic             blk_done,
  input  logic [DW-1:0]    blk_stat,
  output logic             blk_cmplt,
  output logic             chain_cmplt,
  output logic             err
);
  import llw_pkg::*;

  localparam int unsigned IDX_W = $clog2(DESC_WORDS);

  logic [IDX_W-1:0] widx;
  logic             fetch_wr;
  logic             base_load;
  logic [AW-1:0]    base_ptr;
  logic [AW-1:0]    word_addr;
  logic             next_null;
  logic [DW-1:0]    next_word;
  logic [DW-1:0]    ctl_hi_word;

  llw_desc_store #(
    .DW     (DW),
    .NWORDS (DESC_WORDS)
  ) u_store (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (fetch_wr),
    .wr_idx      (widx),
    .wr_data     (mem_rdata),
    .src_word    (blk_src),
    .dst_word    (blk_dst),
    .next_word   (next_word),
    .ctl_lo_word (blk_ctl),
    .ctl_hi_word (ctl_hi_word)
  );

  llw_addr_gen #(
    .AW    (AW),
    .LMS_W (LMS_W),
    .IDX_W (IDX_W)
  ) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (base_load),
    .load_ptr  (base_ptr),
    .idx       (widx),
    .next_ptr  (next_word[AW-1:0]),
    .word_addr (word_addr),
    .next_null (next_null)
  );

  llw_seq #(
    .AW            (AW),
    .DW            (DW),
    .CNT_W         (CNT_W),
    .MAX_COUNT     (MAX_COUNT),
    .DONE_BIT      (DONE_BIT),
    .SRC_CHAIN_BIT (SRC_CHAIN_BIT),
    .DST_CHAIN_BIT (DST_CHAIN_BIT),
    .IDX_W         (IDX_W)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_ptr   (start_ptr),
    .mem_ack     (mem_ack),
    .mem_err     (mem_err),
    .blk_done    (blk_done),
    .blk_stat    (blk_stat),
    .ctl_lo      (blk_ctl),
    .ctl_hi      (ctl_hi_word),
    .next_ptr    (next_word[AW-1:0]),
    .next_null   (next_null),
    .word_addr   (word_addr),
    .base_load   (base_load),
    .base_ptr    (base_ptr),
    .widx        (widx),
    .fetch_wr    (fetch_wr),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .blk_start   (blk_start),
    .blk_cmplt   (blk_cmplt),
    .chain_cmplt (chain_cmplt),
    .err         (err),
    .busy        (busy)
  );

  assign blk_count = ctl_hi_word[CNT_W-1:0];

  // R2
  xfer_fields_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !blk_start && $past(blk_start)) |-> ($stable(blk_src) && $stable(blk_count)));

endmodule

// File: tb/test_llp_chain_walker.sv
module test_llp_chain_walker;

  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_ptr = '0;
  logic          busy, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic          mem_err = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          blk_start;
  logic [DW-1:0] blk_src, blk_dst, blk_ctl;
  logic [11:0]   blk_count;
  logic          blk_done = 1'b0;
  logic [DW-1:0] blk_stat = '0;
  logic          blk_cmplt, chain_cmplt, err;

  always #2.5 clk = ~clk;

  llp_chain_walker #(.AW(AW)) i_llp_chain_walker (
    .clk(clk), .rst(rst), .start(start), .start_ptr(start_ptr), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .blk_start(blk_start), .blk_src(blk_src), .blk_dst(blk_dst), .blk_ctl(blk_ctl),
    .blk_count(blk_count), .blk_done(blk_done), .blk_stat(blk_stat),
    .blk_cmplt(blk_cmplt), .chain_cmplt(chain_cmplt), .err(err)
  );

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  logic [31:0] mem [0:127];

  // per-run expectations
  logic [31:0] e_rd [0:63];
  logic [31:0] e_wa [0:31];
  logic [31:0] e_wd [0:31];
  logic [31:0] e_bs [0:7];
  logic [31:0] e_bd [0:7];
  logic [31:0] e_bl [0:7];
  logic [11:0] e_bn [0:7];
  int e_rd_n, e_wr_n, e_b_n, e_bc, e_cc, e_er;
  int g_rd_n, g_wr_n, g_b_n, g_bc, g_cc, g_er;
  logic [31:0] c_ctlhi [0:3];

  int c_cnt [0:3];
  int c_chain [0:3];
  int lat = 1;
  int err_mode = 0;
  logic [15:0] err_a = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] daddr(input int k);
    return 16'(32'h40 + k * 32'h20);
  endfunction

  // memory responder
  initial begin
    int pend = 0;
    logic [15:0] a = '0;
    logic w = 1'b0;
    logic [31:0] d = '0;
    forever begin
      @(negedge clk);
      mem_ack = 1'b0;
      mem_err = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_ack = 1'b1;
          mem_err = (err_mode == 1 && !w && a == err_a) || (err_mode == 2 && w && a == err_a);
          if (!w) mem_rdata = (a < 16'd512) ? mem[a[8:2]] : 32'h0;
          else if (!mem_err && a < 16'd512) mem[a[8:2]] = d;
        end
      end
      if (mem_req) begin
        a = mem_addr; w = mem_we; d = mem_wdata; pend = lat;
      end
    end
  end

  // block engine
  initial begin
    int xp = 0;
    logic [31:0] s = '0;
    forever begin
      @(negedge clk);
      blk_done = 1'b0;
      if (xp > 0) begin
        xp--;
        if (xp == 0) begin blk_done = 1'b1; blk_stat = s; end
      end
      if (blk_start) begin
        s = blk_src ^ blk_dst ^ {20'h0, blk_count};
        xp = lat + 1;
      end
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_we) begin
        if (g_rd_n < e_rd_n) chk(mem_addr == e_rd[g_rd_n][15:0], "R1 read address", 32'(mem_addr), e_rd[g_rd_n]);
        else chk(1'b0, "R8 unexpected read", 32'(mem_addr), 32'hFFFFFFFF);
        g_rd_n++;
      end
      if (mem_req && mem_we) begin
        if (g_wr_n < e_wr_n) begin
          chk(mem_addr == e_wa[g_wr_n][15:0], "R3 write address", 32'(mem_addr), e_wa[g_wr_n]);
          chk(mem_wdata == e_wd[g_wr_n], "R3 write data", mem_wdata, e_wd[g_wr_n]);
        end else chk(1'b0, "R5 unexpected write", 32'(mem_addr), 32'hFFFFFFFF);
        g_wr_n++;
      end
      if (blk_start) begin
        if (g_b_n < e_b_n) begin
          chk(blk_src == e_bs[g_b_n], "R2 blk_src", blk_src, e_bs[g_b_n]);
          chk(blk_dst == e_bd[g_b_n], "R2 blk_dst", blk_dst, e_bd[g_b_n]);
          chk(blk_ctl == e_bl[g_b_n], "R2 blk_ctl", blk_ctl, e_bl[g_b_n]);
          chk(blk_count == e_bn[g_b_n], "R2 blk_count", 32'(blk_count), 32'(e_bn[g_b_n]));
        end else chk(1'b0, "R4 unexpected blk_start", 32'(blk_count), 32'h0);
        g_b_n++;
      end
      if (blk_cmplt) g_bc++;
      if (err) begin
        g_er++;
        chk(!busy, "R8 busy low with err", 32'(busy), 32'h0);
      end
      if (chain_cmplt) begin
        g_cc++;
        chk(blk_cmplt && !busy, "R7 chain_cmplt with final blk_cmplt", {30'h0, blk_cmplt, busy}, 32'h2);
      end
    end
  end

  task automatic run_case(input int n, input int lms, input int dup);
    logic [31:0] ctllo, ctlhi, src, dst;
    bit stop;
    int cyc;
    for (int i = 0; i < 128; i++) mem[i] = 32'hA5A5_0000 | 32'(i);
    e_rd_n = 0; e_wr_n = 0; e_b_n = 0; e_bc = 0; e_cc = 0; e_er = 0;
    g_rd_n = 0; g_wr_n = 0; g_b_n = 0; g_bc = 0; g_cc = 0; g_er = 0;
    for (int k = 0; k < n; k++) begin
      logic [15:0] b;
      b = daddr(k);
      src = 32'h0001_0000 + 32'(k) * 32'h111 + 32'(lat * 16 + lms);
      dst = (32'h0002_0000 ^ (32'(k) * 32'h0404)) + 32'(n);
      ctllo = 32'h0000_0025;
      if (c_chain[k] == 1 || c_chain[k] == 3) ctllo |= 32'h0800_0000;
      if (c_chain[k] == 2 || c_chain[k] == 3) ctllo |= 32'h1000_0000;
      ctlhi = 32'h5A5A_0000 | 32'(c_cnt[k]);
      c_ctlhi[k] = ctlhi;
      mem[b[8:2] + 0] = src;
      mem[b[8:2] + 1] = dst;
      mem[b[8:2] + 2] = (k == n - 1) ? 32'(lms) : (32'(daddr(k + 1)) | 32'(lms));
      mem[b[8:2] + 3] = ctllo;
      mem[b[8:2] + 4] = ctlhi;
      mem[b[8:2] + 5] = 32'hDEAD_0000 | 32'(k);
      mem[b[8:2] + 6] = 32'hBEEF_0000 | 32'(k);
    end
    // expected behaviour
    stop = 1'b0;
    for (int k = 0; k < n && !stop; k++) begin
      logic [15:0] b;
      logic [31:0] st;
      b = daddr(k);
      for (int w = 0; w < 7 && !stop; w++) begin
        e_rd[e_rd_n] = 32'(b) + 32'(4 * w); e_rd_n++;
        if (err_mode == 1 && err_a == b + 16'(4 * w)) begin e_er = 1; stop = 1'b1; end
      end
      if (!stop && c_cnt[k] > 2048) begin e_er = 1; stop = 1'b1; end
      if (!stop) begin
        if (c_cnt[k] != 0) begin
          e_bs[e_b_n] = mem[b[8:2]]; e_bd[e_b_n] = mem[b[8:2] + 1];
          e_bl[e_b_n] = mem[b[8:2] + 3]; e_bn[e_b_n] = 12'(c_cnt[k]);
          e_b_n++;
          st = mem[b[8:2]] ^ mem[b[8:2] + 1] ^ 32'(c_cnt[k]);
        end else st = 32'h0;
        e_wa[e_wr_n] = 32'(b) + 20; e_wd[e_wr_n] = st; e_wr_n++;
        if (err_mode == 2 && err_a == b + 16'd20) begin e_er = 1; stop = 1'b1; end
      end
      if (!stop) begin
        e_wa[e_wr_n] = 32'(b) + 16; e_wd[e_wr_n] = c_ctlhi[k] | 32'h1000; e_wr_n++;
        if (err_mode == 2 && err_a == b + 16'd16) begin e_er = 1; stop = 1'b1; end
      end
      if (!stop) begin
        e_bc++;
        if (c_chain[k] == 0 || k == n - 1) begin e_cc = 1; stop = 1'b1; end
      end
    end
    // drive
    @(negedge clk);
    start = 1'b1; start_ptr = daddr(0) | 16'((n + lms) % 4);
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      if (dup != 0 && cyc == 6) begin start = 1'b1; start_ptr = daddr(5); end
      else start = 1'b0;
    end
    start = 1'b0;
    repeat (lat + 3) @(negedge clk);
    chk(!busy, "R7 idle after run", 32'(busy), 32'h0);
    chk(g_rd_n == e_rd_n, dup != 0 ? "R1 read count (start while busy)" : "R1 read count", 32'(g_rd_n), 32'(e_rd_n));
    chk(g_wr_n == e_wr_n, "R3 write count", 32'(g_wr_n), 32'(e_wr_n));
    chk(g_b_n == e_b_n, "R2 blk_start count", 32'(g_b_n), 32'(e_b_n));
    chk(g_bc == e_bc, "R3 blk_cmplt count", 32'(g_bc), 32'(e_bc));
    chk(g_cc == e_cc, "R7 chain_cmplt count", 32'(g_cc), 32'(e_cc));
    chk(g_er == e_er, "R8 err count", 32'(g_er), 32'(e_er));
    for (int k = 0; k < n; k++) begin
      logic [31:0] exp4;
      exp4 = (k < e_bc) ? (c_ctlhi[k] | 32'h1000) : c_ctlhi[k];
      chk(mem[daddr(k) >> 2 + 0 + 4] == exp4 || 1'b0 == 1'b1 ? 1'b1 : mem[(daddr(k) >> 2) + 4] == exp4,
          "R6 memory done flag", mem[(daddr(k) >> 2) + 4], exp4);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      nvec++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    chk(!busy && !mem_req && !blk_start && !blk_cmplt && !chain_cmplt && !err,
        "R10 reset outputs", {26'h0, busy, mem_req, blk_start, blk_cmplt, chain_cmplt, err}, 32'h0);

    // R6 R7 main sweep
    for (int n = 1; n <= 4; n++)
      for (int lms = 0; lms < 4; lms++)
        for (int l = 1; l <= 3; l++) begin
          lat = l; err_mode = 0;
          for (int k = 0; k < 4; k++) begin
            c_cnt[k] = 1 + ((n * 5 + k * 11 + lms * 3 + l) % 37);
            c_chain[k] = 1 + ((k + lms) % 3);
          end
          run_case(n, lms, 0);
        end

    // R4 R5 count edges on a single descriptor
    lat = 1; err_mode = 0;
    foreach (c_cnt[i]) c_chain[i] = 3;
    c_cnt[0] = 0;    run_case(1, 1, 0);
    c_cnt[0] = 1;    run_case(1, 2, 0);
    c_cnt[0] = 2047; run_case(1, 0, 0);
    c_cnt[0] = 2048; run_case(1, 3, 0);
    c_cnt[0] = 2049; run_case(1, 0, 0);
    c_cnt[0] = 4095; run_case(1, 2, 0);

    // R4 zero count mid-chain, R5 oversize mid-chain
    c_cnt[0] = 5; c_cnt[1] = 0; c_cnt[2] = 9; run_case(3, 1, 0);
    c_cnt[1] = 2049; run_case(3, 1, 0);

    // R7 chaining disabled with non-null pointer
    c_cnt[0] = 3; c_cnt[1] = 4; c_cnt[2] = 5; c_cnt[3] = 6;
    c_chain[0] = 3; c_chain[1] = 0; c_chain[2] = 3; c_chain[3] = 3;
    run_case(4, 2, 0);

    // R1 start while busy is ignored
    c_chain[1] = 3; lat = 2;
    run_case(3, 0, 1);

    // R8 error on every read and both write-backs
    lat = 1;
    c_cnt[0] = 3; c_cnt[1] = 4; c_chain[0] = 3; c_chain[1] = 3;
    for (int e = 0; e < 2; e++) begin
      for (int w = 0; w < 7; w++) begin
        err_mode = 1; err_a = daddr(e) + 16'(4 * w);
        run_case(2, 1, 0);
      end
      err_mode = 2; err_a = daddr(e) + 16'd20; run_case(2, 1, 0);
      err_mode = 2; err_a = daddr(e) + 16'd16; run_case(2, 1, 0);
    end
    err_mode = 0;

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule